// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address that an SDRAM presents for each data beat of a burst, in the same way the device's internal column counter does. A controller or a memory model pulses `start` with a starting column, a burst-length code and an ordering bit. The block then steps through the burst, one beat for each cycle in which `adv` is high, and flags the final beat of a fixed-length burst.

Two orderings are available. Sequential order counts up from the start column and wraps inside the aligned block the burst occupies. Interleave order XORs the beat number into the low bits of the start column. A full-page burst counts through the whole row, wraps at the row end, and runs until a stop pulse arrives. A new `start` always replaces the running burst, so issuing a start on every cycle gives random column access. A `stop` pulse ends the burst at once.

Top module: `sdr_burst_colgen`

## Requirements
- R1: After reset, `beat_vld` and `beat_last` are 0 and stay 0 until a start is accepted.
- R2: In the cycle after `start` is high, `beat_vld` is 1 and `col` equals the `start_col` sampled with it (beat 0).
- R3: `blen_code` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. The codes 4, 5 and 6 act as a length of 1.
- R4: In sequential order (`itlv_sel`=0), beat i keeps the bits of the start column above log2(L) and sets the low log2(L) bits to (start + i) mod L.
- R5: In interleave order (`itlv_sel`=1), beat i keeps the upper bits and sets the low log2(L) bits to (start XOR i).
- R6: `beat_last` is high on beat L-1 of a fixed-length burst, including the only beat of a length-1 burst. An advance taken on that beat ends the burst, and `beat_vld` is 0 in the next cycle.
- R7: In full-page mode the column increases by one per advance modulo 2^COL_W, the burst never ends by itself, `beat_last` is never high, and `itlv_sel` is ignored (sequential order is used).
- R8: While `adv` is 0 and no start or stop is present, the current beat is held: `col`, `beat_vld` and `beat_last` do not change.
- R9: `stop` ends the running burst, so `beat_vld` is 0 in the next cycle. A `stop` while idle has no effect. When `start` and `stop` are high together, the start wins.
- R10: A start during a burst restarts from the new column with the newly supplied length and order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a new burst at `start_col` |
| start_col | input | COL_W | Starting column of the burst |
| blen_code | input | 3 | Burst-length code (see R3) |
| itlv_sel | input | 1 | 0 = sequential order, 1 = interleave order |
| stop | input | 1 | Terminate the running burst |
| adv | input | 1 | Advance to the next beat |
| col | output | COL_W | Column of the current beat |
| beat_vld | output | 1 | A burst beat is being presented |
| beat_last | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
The assertions check on every cycle the rules that relate one cycle to the next: a start loads its column, a stop or an advance on the last beat ends the burst, a held beat keeps its column, full-page mode steps by one without ever raising the last flag, and every beat stays inside the aligned block of its burst. Only the bench scenarios can show the complete orderings. These are the sequential wrap and the XOR pattern for each length, the treatment of the reserved length codes, the wrap at the row end, and the exact beat on which `beat_last` rises. The bench checks these against column lists computed from the requirement formulas.

// File: rtl/sdr_colgen_pkg.sv
package sdr_colgen_pkg;

   typedef enum logic [2:0] {
      BLEN_1    = 3'd0,
      BLEN_2    = 3'd1,
      BLEN_4    = 3'd2,
      BLEN_8    = 3'd3,
      BLEN_PAGE = 3'd7
   } blen_e;

   localparam int unsigned BLEN_CODE_W = 3;
   localparam int unsigned MAX_FIXED_LOG2 = 3;

endpackage

// File: rtl/sdr_colgen_len_decode.sv
module sdr_colgen_len_decode
   import sdr_colgen_pkg::*;
#(
   parameter int unsigned COL_W       = 8,
   parameter bit          ALLOW_ITLV  = 1'b1
) (
   input  logic [BLEN_CODE_W-1:0] blen_code,
   input  logic                   itlv_req,
   output logic [COL_W-1:0]       wrap_mask,
   output logic                   page_mode,
   output logic                   itlv_eff
);

   always_comb begin
      wrap_mask = '0;
      page_mode = 1'b0;
      unique case (blen_e'(blen_code))
         BLEN_1:    wrap_mask = COL_W'(0);
         BLEN_2:    wrap_mask = COL_W'(1);
         BLEN_4:    wrap_mask = COL_W'(3);
         BLEN_8:    wrap_mask = COL_W'(7);
         BLEN_PAGE: begin
            wrap_mask = '1;
            page_mode = 1'b1;
         end
         default:   wrap_mask = COL_W'(0);
      endcase
   end

   generate
      if (ALLOW_ITLV) begin : g_itlv_on
         assign itlv_eff = itlv_req & ~page_mode;
      end else begin : g_itlv_off
         assign itlv_eff = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/sdr_colgen_order.sv
module sdr_colgen_order #(
   parameter int unsigned COL_W = 8
) (
   input  logic [COL_W-1:0] base_col,
   input  logic [COL_W-1:0] beat_idx,
   input  logic [COL_W-1:0] wrap_mask,
   input  logic             itlv,
   output logic [COL_W-1:0] col
);

   logic [COL_W-1:0] keep_hi;
   logic [COL_W-1:0] seq_low;
   logic [COL_W-1:0] xor_low;

   assign keep_hi = base_col & ~wrap_mask;
   assign seq_low = (base_col + beat_idx) & wrap_mask;
   assign xor_low = (base_col ^ beat_idx) & wrap_mask;
   assign col     = keep_hi | (itlv ? xor_low : seq_low);

endmodule

// File: rtl/sdr_colgen_beat_ctr.sv
module sdr_colgen_beat_ctr #(
   parameter int unsigned COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             halt,
   input  logic             step,
   input  logic [COL_W-1:0] wrap_mask,
   input  logic             page_mode,
   output logic [COL_W-1:0] beat_idx,
   output logic             active,
   output logic             final_beat
);

   logic at_end;

   assign at_end     = ~page_mode & (beat_idx == wrap_mask);
   assign final_beat = active & at_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_idx <= '0;
         active   <= 1'b0;
      end else if (load) begin
         beat_idx <= '0;
         active   <= 1'b1;
      end else if (halt) begin
         active   <= 1'b0;
      end else if (active && step) begin
         if (at_end) begin
            active   <= 1'b0;
         end else begin
            beat_idx <= beat_idx + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen
   import sdr_colgen_pkg::*;
#(
   parameter int unsigned COL_W      = 8,
   parameter bit          ALLOW_ITLV = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [COL_W-1:0]       start_col,
   input  logic [BLEN_CODE_W-1:0] blen_code,
   input  logic                   itlv_sel,
   input  logic                   stop,
   input  logic                   adv,
   output logic [COL_W-1:0]       col,
   output logic                   beat_vld,
   output logic                   beat_last
);

   localparam int unsigned MIN_COL_W = MAX_FIXED_LOG2;

   generate
      if (COL_W < MIN_COL_W) begin : g_bad_width
         $error("sdr_burst_colgen: COL_W must cover an 8-beat block");
      end
      if (COL_W > 16) begin : g_too_wide
         $error("sdr_burst_colgen: COL_W above 16 is not supported");
      end
   endgenerate

   logic [COL_W-1:0] dec_mask;
   logic             dec_page;
   logic             dec_itlv;

   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] mask_q;
   logic             page_q;
   logic             itlv_q;
   logic [COL_W-1:0] beat_idx;

   sdr_colgen_len_decode #(
      .COL_W      (COL_W),
      .ALLOW_ITLV (ALLOW_ITLV)
   ) u_decode (
      .blen_code (blen_code),
      .itlv_req  (itlv_sel),
      .wrap_mask (dec_mask),
      .page_mode (dec_page),
      .itlv_eff  (dec_itlv)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= '0;
         page_q <= 1'b0;
         itlv_q <= 1'b0;
      end else if (start) begin
         base_q <= start_col;
         mask_q <= dec_mask;
         page_q <= dec_page;
         itlv_q <= dec_itlv;
      end
   end

   sdr_colgen_beat_ctr #(
      .COL_W (COL_W)
   ) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (start),
      .halt       (stop),
      .step       (adv),
      .wrap_mask  (mask_q),
      .page_mode  (page_q),
      .beat_idx   (beat_idx),
      .active     (beat_vld),
      .final_beat (beat_last)
   );

   sdr_colgen_order #(
      .COL_W (COL_W)
   ) u_order (
      .base_col  (base_q),
      .beat_idx  (beat_idx),
      .wrap_mask (mask_q),
      .itlv      (itlv_q),
      .col       (col)
   );

endmodule

// File: rtl/sdr_burst_colgen_chk.sv
module sdr_burst_colgen_chk #(
   parameter int unsigned COL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [COL_W-1:0] start_col,
   input logic             stop,
   input logic             adv,
   input logic [COL_W-1:0] col,
   input logic             beat_vld,
   input logic             beat_last,
   input logic [COL_W-1:0] base_q,
   input logic [COL_W-1:0] mask_q,
   input logic             page_q
);

   assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (beat_vld && col == $past(start_col)));

   assert_block_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
      beat_vld |-> (((col ^ base_q) & ~mask_q) == '0));

   assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld && beat_last && adv && !start && !stop) |=> !beat_vld);

   assert_page_no_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (page_q && beat_vld) |-> !beat_last);

   assert_page_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (page_q && beat_vld && adv && !start && !stop) |=>
         (beat_vld && col == COL_W'($past(col) + 1'b1)));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld && !adv && !start && !stop) |=>
         (beat_vld && $stable(col) && $stable(beat_last)));

   assert_stop_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !start) |=> !beat_vld);

endmodule

bind sdr_burst_colgen sdr_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .start_col (start_col),
   .stop      (stop),
   .adv       (adv),
   .col       (col),
   .beat_vld  (beat_vld),
   .beat_last (beat_last),
   .base_q    (base_q),
   .mask_q    (mask_q),
   .page_q    (page_q)
);

// File: tb/test_sdr_burst_colgen.sv
`timescale 1ns/1ps
module test_sdr_burst_colgen;

   localparam int unsigned COL_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [COL_W-1:0] start_col = '0;
   logic [2:0]       blen_code = '0;
   logic             itlv_sel = 1'b0;
   logic             stop = 1'b0;
   logic             adv = 1'b0;
   logic [COL_W-1:0] col;
   logic             beat_vld;
   logic             beat_last;

   always #2 clk = ~clk;

   sdr_burst_colgen #(.COL_W(COL_W)) i_sdr_burst_colgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_col (start_col),
      .blen_code (blen_code),
      .itlv_sel  (itlv_sel),
      .stop      (stop),
      .adv       (adv),
      .col       (col),
      .beat_vld  (beat_vld),
      .beat_last (beat_last)
   );

   typedef struct {
      logic             vld;
      logic [COL_W-1:0] c;
      logic             last;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    n_checks = 0;
   int    n_fails  = 0;
   bit    done     = 1'b0;

   // Scoreboard monitor: samples one cycle of results after each edge.
   always begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
         exp_t  e;
         string t;
         bit    ok;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_checks++;
         if (e.vld) ok = beat_vld && (col == e.c) && (beat_last == e.last);
         else       ok = !beat_vld && !beat_last;
         if (!ok) begin
            n_fails++;
            $display("FAIL %s: got vld=%0b col=%02h last=%0b, expected vld=%0b col=%02h last=%0b",
                     t, beat_vld, col, beat_last, e.vld, e.c, e.last);
         end
      end
   end

   function automatic logic [COL_W-1:0] ref_col(input logic [COL_W-1:0] b,
                                                 input int len, input bit itl, input int i);
      logic [COL_W-1:0] m;
      logic [COL_W-1:0] lo;
      m  = COL_W'(len - 1);
      lo = itl ? ((b ^ COL_W'(i)) & m) : ((b + COL_W'(i)) & m);
      return (b & ~m) | lo;
   endfunction

   task automatic step(input logic s, input logic [COL_W-1:0] c, input logic [2:0] code,
                       input logic itl, input logic stp, input logic a,
                       input logic ev, input logic [COL_W-1:0] ec, input logic el,
                       input string tag);
      exp_t e;
      @(negedge clk);
      start = s; start_col = c; blen_code = code; itlv_sel = itl; stop = stp; adv = a;
      e.vld = ev; e.c = ec; e.last = el;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input string tag);
      step(1'b0, '0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0, tag);
   endtask

   // Full fixed-length burst with continuous advance, then one idle cycle.
   task automatic run_fixed(input logic [COL_W-1:0] b, input logic [2:0] code,
                            input bit itl, input int len, input string tag);
      step(1'b1, b, code, itl, 1'b0, 1'b1, 1'b1, b, (len == 1), tag);
      for (int i = 1; i < len; i++)
         step(1'b0, '0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, ref_col(b, len, itl, i), (i == len - 1), tag);
      idle(tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_checks++;
      if (beat_vld !== 1'b0 || beat_last !== 1'b0) begin
         n_fails++;
         $display("FAIL R1: got vld=%0b last=%0b, expected vld=0 last=0", beat_vld, beat_last);
      end
      idle("R1");

      // R4 sequential, length 4 and 2 and 8
      run_fixed(8'h2E, 3'd2, 1'b0, 4, "R4");
      run_fixed(8'h11, 3'd1, 1'b0, 2, "R4");
      run_fixed(8'h6B, 3'd3, 1'b0, 8, "R4");
      // R5 interleave, length 8 and 4
      run_fixed(8'h35, 3'd3, 1'b1, 8, "R5");
      run_fixed(8'h1E, 3'd2, 1'b1, 4, "R5");
      // R6 length 1, R3 reserved codes act as length 1
      run_fixed(8'hA7, 3'd0, 1'b0, 1, "R6");
      run_fixed(8'h93, 3'd5, 1'b1, 1, "R3");
      run_fixed(8'h44, 3'd4, 1'b0, 1, "R3");

      // R8 hold while adv is low
      step(1'b1, 8'h42, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 8'h42, 1'b0, "R8");
      step(1'b0, '0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h42, 1'b0, "R8");
      step(1'b0, '0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h43, 1'b0, "R8");
      step(1'b0, '0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h43, 1'b0, "R8");
      step(1'b0, '0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h40, 1'b0, "R8");
      step(1'b0, '0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h41, 1'b1, "R8");
      step(1'b0, '0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h41, 1'b1, "R8");
      idle("R6");

      // R7 full page with interleave requested: row wrap, no last flag
      step(1'b1, 8'hFD, 3'd7, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFD, 1'b0, "R7");
      for (int i = 1; i < 6; i++)
         step(1'b0, '0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFD + 8'(i), 1'b0, "R7");
      // R9 stop ends full page; stop while idle does nothing
      step(1'b0, '0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b0, "R9");
      step(1'b0, '0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b0, "R9");
      idle("R9");

      // R9 start wins over simultaneous stop
      step(1'b1, 8'h5A, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 8'h5A, 1'b0, "R9");
      step(1'b0, '0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h5B, 1'b0, "R9");
      step(1'b0, '0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h58, 1'b0, "R9");
      step(1'b0, '0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h59, 1'b1, "R9");
      idle("R9");

      // R10 restart mid-burst with new length and order
      step(1'b1, 8'h10, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 8'h10, 1'b0, "R10");
      step(1'b0, '0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h11, 1'b0, "R10");
      step(1'b0, '0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h12, 1'b0, "R10");
      step(1'b1, 8'h83, 3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h83, 1'b0, "R10");
      step(1'b0, '0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h82, 1'b1, "R10");
      idle("R10");

      // R2 a new column every cycle (random column access)
      for (int k = 0; k < 6; k++)
         step(1'b1, 8'h20 + 8'(k * 37), 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 8'h20 + 8'(k * 37), 1'b0, "R2");
      step(1'b0, '0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, "R9");
      idle("R1");

      while (exp_q.size() > 0) @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got no completion, expected end of scenarios");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

endmodule